// File: doc/BRIEF.md
# Salsa20 Permutation Core

This block computes the Salsa20 core function on a 512-bit state held as sixteen 32-bit words. It is iterative: each clock cycle it applies one half-round, which is four quarterrounds running side by side. The half-rounds alternate between column rounds and row rounds. After the last half-round it adds the original input back, word by word. The result is presented in natural word order with a one-cycle completion strobe.

The caller supplies the state already arranged so that the four column quarterrounds line up in four lanes. Row rounds reuse the same lanes by rotating the second, third and fourth rows inside the datapath. Key expansion, nonce and counter handling, and combining the keystream with data all belong to the surrounding logic.

To use the block, the caller pulses `start` while `busy` is low, together with the state and a round count. It then waits for `done` and takes `dout`.

Top module: `arx_perm_core`

## Requirements
- R1: After reset, `busy` and `done` are low and `dout` is all zeros.
- R2: Input layout: 32-bit field k of `din` (bits 32k+31..32k), with k = 4r+l for row r and lane l (0..3), holds natural state word (4r+5l) mod 16. Output layout: natural word n appears at bits 32n+31..32n of `dout`.
- R3: Each quarterround on (a,b,c,d) runs in this order: b ^= rotl(a+d,7), then c ^= rotl(b+a,9), then d ^= rotl(c+b,13), then a ^= rotl(d+c,18). All sums are modulo 2^32.
- R4: The half-rounds alternate strictly, starting with a column round. A column round works on the quarterround groups (0,4,8,12), (5,9,13,1), (10,14,2,6), (15,3,7,11). A row round works on (0,1,2,3), (5,6,7,4), (10,11,8,9), (15,12,13,14), with the elements of each group listed in (a,b,c,d) order.
- R5: The effective round count N equals `rounds` rounded up to the next even value. A `rounds` value of 0 is treated as 2, and 31 gives 32.
- R6: `start` is accepted when `busy` is low. `busy` reads high from the cycle after the accepting edge. `done` rises on the (N+1)th rising edge after the accepting edge, and `busy` falls on that same edge.
- R7: `done` is high for exactly one cycle per operation.
- R8: `start` is ignored while `busy` is high. The result and the timing of the operation in flight do not change.
- R9: `dout` holds its value in every cycle in which `done` is low.
- R10: After the last round, each word is added to the matching original input word (feedforward). An all-zero input therefore yields an all-zero output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start | input | 1 | Begin an operation (taken only while idle) |
| rounds | input | ROUND_W (5) | Requested round count |
| din | input | 512 | Input state in lane-aligned layout |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle strobe: result valid |
| dout | output | 512 | Result in natural word order |

## Verification
The bench builds the block with the default ROUND_W of 5. That width reaches the largest count, 31, which must round up to 32 and so needs the extra counter bit. The same width also reaches the zero and odd counts that exercise the rounding rule. A second `start` is sent in the middle of a run to show that it cannot disturb the work in flight. Every result is compared against a natural-order model written in the bench.

// File: rtl/arx_pkg.sv
package arx_pkg;
  localparam int WORD_W = 32;
  localparam int LANES  = 4;
  localparam int NWORDS = LANES * LANES;
  localparam int BLK_W  = WORD_W * NWORDS;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [NWORDS-1:0][WORD_W-1:0] blk_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } core_st_e;

  function automatic word_t rotl(input word_t v, input int unsigned s);
    return (v << s) | (v >> (WORD_W - s));
  endfunction
endpackage

// File: rtl/arx_qround.sv
module arx_qround
  import arx_pkg::*;
#(
  parameter int unsigned ROT_B = 7,
  parameter int unsigned ROT_C = 9,
  parameter int unsigned ROT_D = 13,
  parameter int unsigned ROT_A = 18
) (
  input  word_t in_a,
  input  word_t in_b,
  input  word_t in_c,
  input  word_t in_d,
  output word_t out_a,
  output word_t out_b,
  output word_t out_c,
  output word_t out_d
);
  word_t nb, nc, nd, na;

  // strict chain: each step consumes the freshly updated word
  always_comb begin
    nb = in_b ^ rotl(in_a + in_d, ROT_B);
    nc = in_c ^ rotl(nb + in_a, ROT_C);
    nd = in_d ^ rotl(nc + nb, ROT_D);
    na = in_a ^ rotl(nd + nc, ROT_A);
  end

  assign out_a = na;
  assign out_b = nb;
  assign out_c = nc;
  assign out_d = nd;
endmodule

// File: rtl/arx_halfround.sv
module arx_halfround
  import arx_pkg::*;
(
  input  blk_t st_in,
  input  logic row_mode,
  output blk_t st_out
);
  word_t [LANES-1:0] qa_i, qb_i, qc_i, qd_i;
  word_t [LANES-1:0] qa_o, qb_o, qc_o, qd_o;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    localparam int LD = (l + 1) % LANES;
    localparam int LC = (l + 2) % LANES;
    localparam int LB = (l + 3) % LANES;

    // row pass: b role taken by rotated d row, d role by rotated b row
    always_comb begin
      qa_i[l] = st_in[l];
      if (row_mode) begin
        qb_i[l] = st_in[3*LANES + LD];
        qc_i[l] = st_in[2*LANES + LC];
        qd_i[l] = st_in[1*LANES + LB];
      end else begin
        qb_i[l] = st_in[1*LANES + l];
        qc_i[l] = st_in[2*LANES + l];
        qd_i[l] = st_in[3*LANES + l];
      end
    end

    arx_qround u_qr (
      .in_a (qa_i[l]), .in_b (qb_i[l]), .in_c (qc_i[l]), .in_d (qd_i[l]),
      .out_a(qa_o[l]), .out_b(qb_o[l]), .out_c(qc_o[l]), .out_d(qd_o[l])
    );
  end

  // undo the lane rotation when writing back
  for (genvar m = 0; m < LANES; m++) begin : g_wb
    localparam int FB = (m + 1) % LANES;
    localparam int FC = (m + 2) % LANES;
    localparam int FD = (m + 3) % LANES;
    always_comb begin
      st_out[m] = qa_o[m];
      if (row_mode) begin
        st_out[1*LANES + m] = qd_o[FB];
        st_out[2*LANES + m] = qc_o[FC];
        st_out[3*LANES + m] = qb_o[FD];
      end else begin
        st_out[1*LANES + m] = qb_o[m];
        st_out[2*LANES + m] = qc_o[m];
        st_out[3*LANES + m] = qd_o[m];
      end
    end
  end
endmodule

// File: rtl/arx_outmap.sv
module arx_outmap
  import arx_pkg::*;
(
  input  blk_t work,
  input  blk_t orig,
  output blk_t nat
);
  // lane-aligned slot 4r+l carries natural word (4r+5l) mod 16
  for (genvar r = 0; r < LANES; r++) begin : g_row
    for (genvar l = 0; l < LANES; l++) begin : g_col
      localparam int SLOT = LANES*r + l;
      localparam int NIDX = (LANES*r + (LANES+1)*l) % NWORDS;
      assign nat[NIDX] = work[SLOT] + orig[SLOT];
    end
  end
endmodule

// File: rtl/arx_perm_core.sv
module arx_perm_core
  import arx_pkg::*;
#(
  parameter int ROUND_W = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [ROUND_W-1:0] rounds,
  input  logic [BLK_W-1:0]   din,
  output logic               busy,
  output logic               done,
  output logic [BLK_W-1:0]   dout
);
  localparam int CNT_W = ROUND_W + 1;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  core_st_e          st_q, st_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d, eff_cnt;
  logic              row_q, row_d;
  logic              done_q, done_d;
  blk_t              work_q, work_d, orig_q, hr_out, nat_res, dout_q;
  logic              load, step, fin;

  always_comb begin
    eff_cnt = {1'b0, rounds} + CNT_W'(rounds[0]);
    if (eff_cnt == '0) eff_cnt = CNT_W'(2);
  end

  arx_halfround u_half (
    .st_in   (work_q),
    .row_mode(row_q),
    .st_out  (hr_out)
  );

  arx_outmap u_out (
    .work(work_q),
    .orig(orig_q),
    .nat (nat_res)
  );

  // next state
  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    row_d = row_q;
    load  = 1'b0;
    step  = 1'b0;
    fin   = 1'b0;
    unique case (st_q)
      ST_IDLE: if (start) begin
        st_d  = ST_RUN;
        cnt_d = eff_cnt;
        row_d = 1'b0;
        load  = 1'b1;
      end
      ST_RUN: begin
        step  = 1'b1;
        cnt_d = cnt_q - CNT_W'(1);
        row_d = ~row_q;
        if (cnt_q == CNT_W'(1)) st_d = ST_FIN;
      end
      ST_FIN: begin
        fin  = 1'b1;
        st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
    work_d = load ? blk_t'(din) : hr_out;
    done_d = fin;
  end

  // registers
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      row_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      row_q  <= row_d;
      done_q <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      work_q <= '0;
      orig_q <= '0;
      dout_q <= '0;
    end else begin
      if (load | step) work_q <= work_d;
      if (load)        orig_q <= blk_t'(din);
      if (fin)         dout_q <= nat_res;
    end
  end

  assign busy = (st_q != ST_IDLE);
  assign done = done_q;
  assign dout = dout_q;

  // checks next to the control they guard
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_i_n)
    done_q |=> !done_q);

  assert_done_idle_R6: assert property (@(posedge clk) disable iff (!rst_i_n)
    done_q |-> !busy);

  assert_start_take_R6: assert property (@(posedge clk) disable iff (!rst_i_n)
    (start && !busy) |=> busy);

  assert_cnt_live_R5: assert property (@(posedge clk) disable iff (!rst_i_n)
    (st_q == ST_RUN) |-> (cnt_q != '0));

  assert_first_col_R4: assert property (@(posedge clk) disable iff (!rst_i_n)
    (st_q == ST_RUN && $past(st_q) == ST_IDLE) |-> !row_q);

  assert_alternate_R4: assert property (@(posedge clk) disable iff (!rst_i_n)
    (st_q == ST_RUN && $past(st_q) == ST_RUN) |-> (row_q != $past(row_q)));

  assert_orig_kept_R8: assert property (@(posedge clk) disable iff (!rst_i_n)
    busy |=> $stable(orig_q));

  assert_hold_out_R9: assert property (@(posedge clk) disable iff (!rst_i_n)
    !done_q |-> $stable(dout_q));
endmodule

// File: tb/arx_perm_core_test.sv
module arx_perm_core_test;
  localparam int CLK_PERIOD = 10;
  localparam int ROUND_W    = 5;
  localparam int MAX_CYC    = 200000;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               start = 1'b0;
  logic [ROUND_W-1:0] rounds = '0;
  logic [511:0]       din = '0;
  logic               busy, done;
  logic [511:0]       dout;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  arx_perm_core #(.ROUND_W(ROUND_W)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .rounds(rounds),
    .din(din), .busy(busy), .done(done), .dout(dout)
  );

  function automatic logic [31:0] rl(input logic [31:0] v, input int s);
    return (v << s) | (v >> (32 - s));
  endfunction

  function automatic void qr(inout logic [15:0][31:0] x,
                             input int a, input int b, input int c, input int d);
    x[b] = x[b] ^ rl(x[a] + x[d], 7);
    x[c] = x[c] ^ rl(x[b] + x[a], 9);
    x[d] = x[d] ^ rl(x[c] + x[b], 13);
    x[a] = x[a] ^ rl(x[d] + x[c], 18);
  endfunction

  // natural-order model
  function automatic logic [15:0][31:0] model(input logic [15:0][31:0] x0, input int n);
    logic [15:0][31:0] x = x0;
    for (int i = 0; i < n/2; i++) begin
      qr(x, 0, 4, 8, 12);  qr(x, 5, 9, 13, 1);
      qr(x, 10, 14, 2, 6); qr(x, 15, 3, 7, 11);
      qr(x, 0, 1, 2, 3);   qr(x, 5, 6, 7, 4);
      qr(x, 10, 11, 8, 9); qr(x, 15, 12, 13, 14);
    end
    for (int k = 0; k < 16; k++) x[k] = x[k] + x0[k];
    return x;
  endfunction

  // R2 input layout: slot 4r+l <- natural (4r+5l) mod 16
  function automatic logic [511:0] lay(input logic [15:0][31:0] nat);
    logic [511:0] v;
    for (int r = 0; r < 4; r++)
      for (int l = 0; l < 4; l++)
        v[32*(4*r+l) +: 32] = nat[(4*r + 5*l) % 16];
    return v;
  endfunction

  function automatic int eff_of(input int r);
    int e = r + (r % 2);
    return (e == 0) ? 2 : e;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [511:0] act,
                     input logic [511:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [15:0][31:0] nat, input int r, input bit poke);
    logic [511:0] expv;
    logic [511:0] held;
    int n = eff_of(r);
    int lat = 0;
    expv = model(nat, n);
    @(negedge clk);
    din = lay(nat); rounds = ROUND_W'(r); start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    chk(busy === 1'b1, "R6 busy after accept", {511'b0, busy}, 512'd1);
    while (done !== 1'b1 && lat < 100) begin
      if (poke && lat == 2) begin
        @(negedge clk);
        start = 1'b1; din = ~din; rounds = ROUND_W'(3);
        @(posedge clk); #1; lat++;
        start = 1'b0;
      end else begin
        @(posedge clk); #1; lat++;
      end
    end
    chk(lat == n + 1, "R6 latency", 512'(lat), 512'(n + 1));
    chk(busy === 1'b0, "R6 busy low at done", {511'b0, busy}, 512'd0);
    chk(dout === expv, poke ? "R8 R3 result under busy start" : "R2,R3,R4,R5 result",
        dout, expv);
    held = dout;
    @(posedge clk); #1;
    chk(done === 1'b0, "R7 done single cycle", {511'b0, done}, 512'd0);
    chk(dout === held, "R9 output held", dout, held);
    chk(busy === 1'b0, "R8 second start not taken", {511'b0, busy}, 512'd0);
  endtask

  initial begin : watchdog
    wait (cyc >= MAX_CYC);
    failures++;
    $display("FAIL watchdog actual=%0d expected<%0d", cyc, MAX_CYC);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    logic [15:0][31:0] v;
    int rsel;
    void'($urandom(32'h5A17));
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state, checked while reset is held
    chk(busy === 1'b0, "R1 busy", {511'b0, busy}, 512'd0);
    chk(done === 1'b0, "R1 done", {511'b0, done}, 512'd0);
    chk(dout === '0, "R1 dout", dout, 512'd0);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R10 zero input stays zero
    v = '0;
    run_op(v, 8, 1'b0);
    chk(dout === '0, "R10 zero in zero out", dout, 512'd0);

    v = '1;                     run_op(v, 20, 1'b0);
    for (int k = 0; k < 16; k++) v[k] = $urandom;
    run_op(v, 12, 1'b0);
    // R5 rounding corners
    run_op(v, 7, 1'b0);
    run_op(v, 0, 1'b0);
    run_op(v, 31, 1'b0);
    run_op(v, 1, 1'b0);
    // R8 start while busy
    run_op(v, 20, 1'b1);

    for (int t = 0; t < 12; t++) begin
      for (int k = 0; k < 16; k++) v[k] = $urandom;
      rsel = $urandom % 3;
      run_op(v, (rsel == 0) ? 8 : (rsel == 1) ? 12 : 20, (t % 3) == 0);
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule